// File: doc/BRIEF.md
# I2C bit-rate prescaler

This block turns the system clock into the timing enables an I2C master core needs to pace the bus. A 7-bit baud setting holds a linear factor M (0 to 15) and an exponent N (0 to 7). The divider chain has three stages. The first is a power-of-two stage. The second is a linear stage that counts M+1 of those periods. The third is a fixed split of every bit into ten equal sub-intervals. With these stages, the master core can place its SCL edges and SDA sample points on sub-tick boundaries.

Two single-cycle pulses come out. The first is a sub-tick at the start of every sub-interval. The second is a bit-start pulse that shares a cycle with the first sub-tick of each bit. Software writes the baud setting at any time. The active divider picks up the new value only when the next bit begins, so the current bit always completes with a single spacing. A parameter chooses the exponent of the power-of-two stage: N+1 (the default) or N. Hardware reset and a synchronous soft reset both return the setting to 0x44 (M=8, N=4) and restart the divider chain.

Top module: `i2c_bit_prescaler`

## Requirements
- R1: After hardware reset both pulse outputs are low while reset is held. In the first cycle after the first clock edge with reset released, sub_tick and bit_start are both high. The setting in force is then 0x44.
- R2: In the default variant, consecutive sub_tick pulses are exactly (M+1) * 2^(N+1) clock cycles apart. With the reset setting this is 288 cycles.
- R3: Each bit consists of ten sub-ticks. bit_start is high only together with sub_tick, and it is high on every tenth sub_tick, so bit_start pulses are ten sub-intervals apart.
- R4: The baud setting is 7 bits wide. M is in bits [6:3] and N is in bits [2:0]. For example, 0x11 means M=2, N=1, and 0x0A means M=1, N=2.
- R5: A write does not change the bit in progress. The remaining sub-intervals of that bit keep the old spacing, and the new spacing starts with the next bit_start.
- R6: While soft_rst is high, both outputs are low and the setting returns to 0x44. In the first cycle after the first edge with soft_rst low, both outputs pulse, and the spacing is that of 0x44.
- R7: With POW2_MODE set to POW2_EXP_N, the power-of-two stage divides by 2^N instead of 2^(N+1). Sub-ticks are then (M+1) * 2^N cycles apart, which is 144 cycles at the reset setting.
- R8: bit_start is always exactly one clock wide. sub_tick is also one clock wide whenever its spacing is two cycles or more.
- R9: Both ends of the range work as follows.
  - Setting 0x00 gives a 2-cycle spacing in the default variant and a 1-cycle spacing in the other, where sub_tick stays high.
  - Setting 0x7F gives 4096 and 2048 cycles respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset: restores setting 0x44 and restarts the chain |
| baud_we | input | 1 | Write strobe for the baud setting |
| baud_wdata | input | 7 | New baud setting: M in [6:3], N in [2:0] |
| sub_tick | output | 1 | One-cycle pulse at the start of each of the ten sub-intervals of a bit |
| bit_start | output | 1 | One-cycle pulse with the first sub-tick of each bit |

## Verification
Both pulses are registered. The first pulse after a reset release is therefore visible in the cycle after the first edge, and the bench samples it at the next falling edge. The bench checks every later pulse as a difference of a free-running edge count, which must equal (M+1) times the stage-one period exactly, or ten times that between bit starts. The write task returns only after the capturing edge has passed. Spacing measurements start from the first bit_start after that edge, which is the earliest edge at which the new setting may apply. The bench also follows the old bit through all ten of its sub-ticks to confirm the change waits for the boundary.

// File: rtl/i2c_presc_pkg.sv
package i2c_presc_pkg;

   // Exponent choice for the power-of-two stage.
   typedef enum logic {
      POW2_EXP_N        = 1'b0,
      POW2_EXP_N_PLUS_1 = 1'b1
   } pow2_mode_e;

   localparam int unsigned PRESC_M_W_DEF       = 4;
   localparam int unsigned PRESC_N_W_DEF       = 3;
   localparam int unsigned PRESC_SUB_TICKS_DEF = 10;
   localparam int unsigned PRESC_RESET_DEF     = 'h44;

   // Counter width the power-of-two stage needs for a given exponent field.
   function automatic int unsigned pow2_cnt_width(input int unsigned n_w,
                                                  input pow2_mode_e mode);
      return ((1 << n_w) - 1) + ((mode == POW2_EXP_N_PLUS_1) ? 1 : 0);
   endfunction

endpackage

// File: rtl/i2c_presc_baud_reg.sv
module i2c_presc_baud_reg
   import i2c_presc_pkg::*;
#(
   parameter int unsigned M_W       = PRESC_M_W_DEF,
   parameter int unsigned N_W       = PRESC_N_W_DEF,
   parameter int unsigned RESET_VAL = PRESC_RESET_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               we_i,
   input  logic [M_W+N_W-1:0] wdata_i,
   input  logic               load_i,
   output logic [M_W-1:0]     m_o,
   output logic [N_W-1:0]     n_o
);

   localparam int unsigned BAUD_W = M_W + N_W;
   localparam logic [BAUD_W-1:0] RST_CODE = BAUD_W'(RESET_VAL);

   logic [BAUD_W-1:0] pending_q;
   logic [BAUD_W-1:0] active_q;

   // Software-visible setting: written at any time.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= RST_CODE;
      end else if (soft_rst) begin
         pending_q <= RST_CODE;
      end else if (we_i) begin
         pending_q <= wdata_i;
      end
   end

   // Setting in force: only moves at a bit boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= RST_CODE;
      end else if (soft_rst) begin
         active_q <= RST_CODE;
      end else if (load_i) begin
         active_q <= pending_q;
      end
   end

   assign m_o = active_q[BAUD_W-1:N_W];
   assign n_o = active_q[N_W-1:0];

   // R5: the divider setting never moves inside a bit
   p_hold_mid_bit_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !soft_rst) |=> $stable(active_q));

   // R6: a soft reset restores the default in both copies
   p_soft_default_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (active_q == RST_CODE) && (pending_q == RST_CODE));

endmodule

// File: rtl/i2c_presc_pow2_stage.sv
module i2c_presc_pow2_stage
   import i2c_presc_pkg::*;
#(
   parameter int unsigned N_W  = PRESC_N_W_DEF,
   parameter pow2_mode_e  MODE = POW2_EXP_N_PLUS_1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr_i,
   input  logic [N_W-1:0] n_i,
   output logic           done_o
);

   localparam int unsigned CNT_W = pow2_cnt_width(N_W, MODE);

   logic [N_W:0]       exp_w;
   logic [CNT_W-1:0]   mask_w;
   logic [CNT_W-1:0]   cnt_q;

   generate
      if (MODE == POW2_EXP_N_PLUS_1) begin : g_exp_plus_one
         assign exp_w = {1'b0, n_i} + 1'b1;
      end else begin : g_exp_plain
         assign exp_w = {1'b0, n_i};
      end
   endgenerate

   // Terminal count 2^exp - 1.
   assign mask_w = ~({CNT_W{1'b1}} << exp_w);
   assign done_o = (cnt_q == mask_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i || done_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: the stage never runs past the period its exponent selects
   p_pow2_in_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= mask_w);

endmodule

// File: rtl/i2c_presc_lin_stage.sv
module i2c_presc_lin_stage
   import i2c_presc_pkg::*;
#(
   parameter int unsigned M_W = PRESC_M_W_DEF
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr_i,
   input  logic           step_i,
   input  logic [M_W-1:0] m_i,
   output logic           done_o
);

   logic [M_W-1:0] cnt_q;

   assign done_o = step_i && (cnt_q == m_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= (cnt_q == m_i) ? '0 : cnt_q + 1'b1;
      end
   end

   // R2: the linear stage counts M+1 steps, never more
   p_lin_in_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= m_i);

endmodule

// File: rtl/i2c_presc_phase.sv
module i2c_presc_phase
   import i2c_presc_pkg::*;
#(
   parameter int unsigned SUB_TICKS = PRESC_SUB_TICKS_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic lin_done_i,
   output logic start_o,
   output logic load_o,
   output logic sub_tick_o,
   output logic bit_start_o
);

   localparam int unsigned PH_W = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(SUB_TICKS - 1);

   logic            start_q;
   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_next;
   logic            fire;
   logic            sub_q;
   logic            bit_q;

   assign fire    = start_q || lin_done_i;
   assign ph_next = (start_q || (ph_q == PH_LAST)) ? '0 : ph_q + 1'b1;
   assign load_o  = fire && (ph_next == '0);
   assign start_o = start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b1;
         ph_q    <= '0;
         sub_q   <= 1'b0;
         bit_q   <= 1'b0;
      end else if (soft_rst) begin
         start_q <= 1'b1;
         ph_q    <= '0;
         sub_q   <= 1'b0;
         bit_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         sub_q   <= fire;
         bit_q   <= load_o;
         if (fire) begin
            ph_q <= ph_next;
         end
      end
   end

   assign sub_tick_o  = sub_q;
   assign bit_start_o = bit_q;

   // R3: a bit start is always also a sub-tick
   p_bit_on_sub_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_q |-> sub_q);

   // R3: the sub-interval index stays below the per-bit count
   p_phase_in_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      ph_q <= PH_LAST);

   // R8: bit start lasts one cycle
   p_bit_one_wide_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_q |=> !bit_q);

   // R1: leaving the start state emits both pulses at once
   p_first_pulse_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && !soft_rst) |=> (sub_q && bit_q));

endmodule

// File: rtl/i2c_bit_prescaler.sv
module i2c_bit_prescaler
   import i2c_presc_pkg::*;
#(
   parameter int unsigned M_W        = PRESC_M_W_DEF,
   parameter int unsigned N_W        = PRESC_N_W_DEF,
   parameter int unsigned SUB_TICKS  = PRESC_SUB_TICKS_DEF,
   parameter int unsigned BAUD_RESET = PRESC_RESET_DEF,
   parameter pow2_mode_e  POW2_MODE  = POW2_EXP_N_PLUS_1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               baud_we,
   input  logic [M_W+N_W-1:0] baud_wdata,
   output logic               sub_tick,
   output logic               bit_start
);

   localparam int unsigned BAUD_W = M_W + N_W;

   // Elaboration-time parameter checks.
   generate
      if (M_W < 1 || M_W > 8) begin : g_bad_m_w
         $error("i2c_bit_prescaler: M_W must be 1..8");
      end
      if (N_W < 1 || N_W > 4) begin : g_bad_n_w
         $error("i2c_bit_prescaler: N_W must be 1..4");
      end
      if (SUB_TICKS < 2) begin : g_bad_sub
         $error("i2c_bit_prescaler: SUB_TICKS must be at least 2");
      end
      if (BAUD_RESET >= (1 << BAUD_W)) begin : g_bad_reset
         $error("i2c_bit_prescaler: BAUD_RESET does not fit the baud field");
      end
   endgenerate

   logic [M_W-1:0] m_act;
   logic [N_W-1:0] n_act;
   logic           start_w;
   logic           load_w;
   logic           pow2_done;
   logic           lin_done;
   logic           clr_w;

   assign clr_w = start_w || soft_rst;

   i2c_presc_baud_reg #(
      .M_W       (M_W),
      .N_W       (N_W),
      .RESET_VAL (BAUD_RESET)
   ) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .we_i     (baud_we),
      .wdata_i  (baud_wdata),
      .load_i   (load_w),
      .m_o      (m_act),
      .n_o      (n_act)
   );

   i2c_presc_pow2_stage #(
      .N_W  (N_W),
      .MODE (POW2_MODE)
   ) u_pow2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_w),
      .n_i    (n_act),
      .done_o (pow2_done)
   );

   i2c_presc_lin_stage #(
      .M_W (M_W)
   ) u_lin (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_w),
      .step_i (pow2_done),
      .m_i    (m_act),
      .done_o (lin_done)
   );

   i2c_presc_phase #(
      .SUB_TICKS (SUB_TICKS)
   ) u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (soft_rst),
      .lin_done_i  (lin_done),
      .start_o     (start_w),
      .load_o      (load_w),
      .sub_tick_o  (sub_tick),
      .bit_start_o (bit_start)
   );

endmodule

// File: tb/i2c_bit_prescaler_tb.sv
`timescale 1ns/1ps
module i2c_bit_prescaler_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       baud_we = 1'b0;
   logic [6:0] baud_wdata = '0;
   logic       sub_d, bit_d, sub_v, bit_v;
   longint     cyc = 0;
   int         n_chk = 0;
   int         n_bad = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   i2c_bit_prescaler u_dut (
      .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst),
      .baud_we (baud_we), .baud_wdata (baud_wdata),
      .sub_tick (sub_d), .bit_start (bit_d)
   );

   i2c_bit_prescaler #(.POW2_MODE (i2c_presc_pkg::POW2_EXP_N)) u_dut_v (
      .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst),
      .baud_we (baud_we), .baud_wdata (baud_wdata),
      .sub_tick (sub_v), .bit_start (bit_v)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic next_sub(input bit sel, output longint t, output bit bs);
      bit got = 1'b0;
      while (!got) begin
         @(negedge clk);
         if ((sel ? sub_v : sub_d) === 1'b1) begin
            got = 1'b1;
            t   = cyc;
            bs  = sel ? bit_v : bit_d;
         end
      end
   endtask

   task automatic next_bit(input bit sel, output longint t);
      bit got = 1'b0;
      while (!got) begin
         @(negedge clk);
         if ((sel ? bit_v : bit_d) === 1'b1) begin
            got = 1'b1;
            t   = cyc;
         end
      end
   endtask

   task automatic write_baud(input logic [6:0] v);
      @(negedge clk);
      baud_we    = 1'b1;
      baud_wdata = v;
      @(negedge clk);
      baud_we    = 1'b0;
   endtask

   task automatic measure(input bit sel, input longint exp, input string req);
      longint t0, t1;
      bit     bs;
      next_bit(sel, t0);
      next_sub(sel, t1, bs);
      check(req, sel ? "variant sub spacing" : "default sub spacing", t1 - t0, exp);
   endtask

   task automatic t_reset();
      longint t0, t, a, b;
      bit     bs;
      repeat (3) @(negedge clk);
      check("R1", "sub_tick in reset", sub_d, 0);
      check("R1", "bit_start in reset", bit_d, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "first sub_tick", sub_d, 1);
      check("R1", "first bit_start", bit_d, 1);
      check("R1", "variant first bit_start", bit_v, 1);
      t0 = cyc;
      @(negedge clk);
      check("R8", "bit_start one wide", bit_d, 0);
      check("R8", "sub_tick one wide", sub_d, 0);
      for (int i = 1; i <= 10; i++) begin
         next_sub(1'b0, t, bs);
         check("R2", "reset spacing 288", t - t0, 288);
         check("R3", "bit_start on tenth sub", bs, (i == 10));
         t0 = t;
      end
      next_bit(1'b1, a);
      next_bit(1'b1, b);
      check("R7", "variant bit period", b - a, 1440);
      measure(1'b1, 144, "R7");
   endtask

   task automatic t_layout();
      write_baud(7'h11);
      measure(1'b0, 12, "R4");
      measure(1'b1, 6, "R4");
      write_baud(7'h0A);
      measure(1'b0, 16, "R4");
      measure(1'b1, 8, "R4");
   endtask

   task automatic t_switch();
      longint t0, t;
      bit     bs;
      next_bit(1'b0, t0);
      write_baud(7'h21);
      for (int i = 1; i <= 10; i++) begin
         next_sub(1'b0, t, bs);
         check("R5", "old spacing kept", t - t0, 16);
         check("R5", "boundary position", bs, (i == 10));
         t0 = t;
      end
      next_sub(1'b0, t, bs);
      check("R5", "new spacing after boundary", t - t0, 20);
   endtask

   task automatic t_min();
      longint t0, a, b;
      write_baud(7'h00);
      next_bit(1'b0, t0);
      @(negedge clk);
      check("R8", "gap at spacing 2", sub_d, 0);
      @(negedge clk);
      check("R9", "pulse at spacing 2", sub_d, 1);
      next_bit(1'b1, t0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R9", "variant sub_tick held", sub_v, 1);
      end
      next_bit(1'b1, a);
      next_bit(1'b1, b);
      check("R3", "variant ten-cycle bit", b - a, 10);
   endtask

   task automatic t_max();
      write_baud(7'h7F);
      measure(1'b0, 4096, "R9");
      measure(1'b1, 2048, "R9");
   endtask

   task automatic t_soft();
      longint t0, tv, td;
      bit     bs;
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      check("R6", "sub_tick in soft reset", sub_d, 0);
      check("R6", "bit_start in soft reset", bit_d, 0);
      check("R6", "variant sub in soft reset", sub_v, 0);
      soft_rst = 1'b0;
      @(negedge clk);
      check("R6", "pulse after soft reset", sub_d & bit_d, 1);
      check("R6", "variant pulse after soft reset", sub_v & bit_v, 1);
      t0 = cyc;
      next_sub(1'b1, tv, bs);
      check("R6", "variant default restored", tv - t0, 144);
      next_sub(1'b0, td, bs);
      check("R6", "default restored", td - t0, 288);
   endtask

   initial begin
      t_reset();
      t_layout();
      t_switch();
      t_min();
      t_max();
      t_soft();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule